// File: doc/BRIEF.md
# Scanline/Cycle Interrupt Timer

This block is an interrupt timer for a cartridge memory mapper. It listens to the CPU write bus (address, data byte, write strobe) and keeps an 8-bit down-counter. The counter steps on timer events. A mode bit chooses where those events come from: either a prescaler that fires once every four CPU clock cycles, or the rising edges of a scanline pulse input that is brought into the CPU clock domain.

Each time the counter reaches zero while the timer is enabled, the block starts a short delay. When the delay runs out, it pulls an active-low interrupt line. The line stays low until software acknowledges it by writing either of the two enable-control registers. A reload request loads the counter from a latch. When the latch value is non-zero, that forced load also sets the counter's lowest bit.

Top module: `line_irq_timer`

## Requirements
- R1: Register selection looks only at address bits 15, 14, 13 and 0 (mask 0xE001). Under that mask, 0xC000 is the latch, 0xC001 is the reload/mode register, 0xE000 is disable and 0xE001 is enable. A write to any other masked address has no effect.
- R2: A write to the latch register stores the 8-bit data byte as the reload value.
- R3: A write to the reload/mode register sets a pending-reload flag. It copies data bit 0 into the mode (1 = CPU-cycle events, 0 = scanline events) and clears the prescaler.
- R4: A write to the disable register clears the enable flag, deasserts the interrupt output at the next edge, and cancels any delay that is running.
- R5: A write to the enable register sets the enable flag and deasserts the interrupt output at the next edge.
- R6: On an event with a reload pending, the counter takes the latch value with bit 0 forced to 1 when the latch is non-zero, and the pending flag clears.
- R7: On an event with no reload pending, a counter at zero reloads the latch value unchanged, and any other counter value decrements by one.
- R8: When an event leaves the counter at zero with enable set, the interrupt output falls exactly 4 clock cycles after that event's edge.
- R9: In CPU-cycle mode, events happen on the 4th, 8th, 12th … clock edge after the reload/mode write.
- R10: In scanline mode, each rising edge of the scanline input gives exactly one event. The event takes effect on the second clock edge after the first edge that samples the input high, and clock cycles alone give no events.
- R11: While the timer is disabled, the counter keeps stepping on events but never starts the interrupt delay.
- R12: The interrupt output is active low. Once low, it stays low until an acknowledge write. Reset leaves it high and clears the counter, latch, flags, delay and mode (scanline).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_pulse | input | 1 | Scanline pulse, asynchronous to clk |
| irq_n | output | 1 | Active-low interrupt, held until acknowledged |

## Verification
The assertions check the per-cycle rules on every cycle:
- an acknowledge write always releases the interrupt line;
- the line never releases on its own;
- it only falls at the end of a delay;
- a disabled timer never starts a delay;
- a forced reload always leaves an odd counter, or a zero counter only when the latch is zero.

Exact interval arithmetic can only be shown by the bench's scenarios. These cover the reload-to-interrupt latency across a sweep of latch values, the period after natural reloads, counting that goes on while disabled, cancellation, the mirrored addresses, and the scanline synchronizer latency.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

  // One-hot register strobes produced by the address decoder
  typedef struct packed {
    logic latch_wr;
    logic reload_wr;
    logic dis_wr;
    logic en_wr;
  } irqt_cmd_t;

  // Event source selection
  typedef enum logic {
    SRC_LINE = 1'b0,
    SRC_CPU  = 1'b1
  } irqt_src_e;

endpackage

// File: rtl/irqt_decode.sv
module irqt_decode
  import irqt_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter [ADDR_W-1:0] DEC_MASK  = 16'hE001,
  parameter [ADDR_W-1:0] LATCH_A   = 16'hC000,
  parameter [ADDR_W-1:0] RELOAD_A  = 16'hC001,
  parameter [ADDR_W-1:0] DIS_A     = 16'hE000,
  parameter [ADDR_W-1:0] EN_A      = 16'hE001
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output irqt_cmd_t         cmd
);

  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked       = wr_addr & DEC_MASK;
    cmd.latch_wr  = wr_en && (masked == LATCH_A);
    cmd.reload_wr = wr_en && (masked == RELOAD_A);
    cmd.dis_wr    = wr_en && (masked == DIS_A);
    cmd.en_wr     = wr_en && (masked == EN_A);
  end

endmodule

// File: rtl/irqt_event_gen.sv
module irqt_event_gen
  import irqt_pkg::*;
#(
  parameter int PRESC_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  irqt_src_e src,
  input  logic      presc_clr,
  input  logic      line_pulse,
  output logic      evt
);

  logic [PRESC_W-1:0] presc_q;
  logic               cpu_tick;
  logic               line_s;
  logic               line_prev_q;
  logic               line_evt;

  // Free-running prescaler, cleared by a reload/mode write
  always_ff @(posedge clk) begin
    if (rst || presc_clr) presc_q <= '0;
    else                  presc_q <= presc_q + 1'b1;
  end

  assign cpu_tick = &presc_q;

  // Synchronizer chain; depth picks the variant
  generate
    if (SYNC_STAGES <= 1) begin : g_sync_one
      logic s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b0;
        else     s_q <= line_pulse;
      end
      assign line_s = s_q;
    end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= {s_q[SYNC_STAGES-2:0], line_pulse};
      end
      assign line_s = s_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) line_prev_q <= 1'b0;
    else     line_prev_q <= line_s;
  end

  assign line_evt = line_s & ~line_prev_q;
  assign evt      = (src == SRC_CPU) ? cpu_tick : line_evt;

endmodule

// File: rtl/irqt_count_core.sv
module irqt_count_core
  import irqt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             latch_wr,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] wr_data,
  output irqt_src_e        src,
  output logic [CNT_W-1:0] latch_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             reload_q,
  output logic             zero_evt
);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (reload_q)
      cnt_nxt = latch_q | {{(CNT_W-1){1'b0}}, |latch_q};
    else if (cnt_q == '0)
      cnt_nxt = latch_q;
    else
      cnt_nxt = cnt_q - 1'b1;
  end

  assign zero_evt = evt && (cnt_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= '0;
      cnt_q    <= '0;
      reload_q <= 1'b0;
      src      <= SRC_LINE;
    end else begin
      if (latch_wr) latch_q <= wr_data;
      if (evt)      cnt_q   <= cnt_nxt;
      if (reload_wr) begin
        reload_q <= 1'b1;
        src      <= irqt_src_e'(wr_data[0]);
      end else if (evt) begin
        reload_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irqt_irq_out.sv
module irqt_irq_out #(
  parameter int DELAY = 4,
  localparam int DW   = $clog2(DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zero_evt,
  input  logic          en_set,
  input  logic          en_clr,
  output logic          en_q,
  output logic [DW-1:0] dly_q,
  output logic          irq_n
);

  localparam logic [DW-1:0] DLY_LOAD = DW'(DELAY);
  localparam logic [DW-1:0] DLY_ONE  = DW'(1);

  logic irq_q;
  logic ack;

  assign ack = en_set | en_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      dly_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_clr)      en_q <= 1'b0;
      else if (en_set) en_q <= 1'b1;

      if (en_clr)
        dly_q <= '0;
      else if (zero_evt && en_q)
        dly_q <= DLY_LOAD;
      else if (dly_q != '0)
        dly_q <= dly_q - 1'b1;

      if (ack)                  irq_q <= 1'b0;
      else if (dly_q == DLY_ONE) irq_q <= 1'b1;
    end
  end

  assign irq_n = ~irq_q;

endmodule

// File: rtl/line_irq_timer.sv
module line_irq_timer
  import irqt_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PRESC_W     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DELAY       = 4,
  localparam int DW         = $clog2(DELAY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_pulse,
  output logic              irq_n
);

  irqt_cmd_t         cmd;
  irqt_src_e         src;
  logic              evt_w;
  logic [DATA_W-1:0] latch_w;
  logic [DATA_W-1:0] cnt_w;
  logic              reload_w;
  logic              zero_w;
  logic              en_w;
  logic [DW-1:0]     dly_w;

  irqt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmd     (cmd)
  );

  irqt_event_gen #(.PRESC_W(PRESC_W), .SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .src        (src),
    .presc_clr  (cmd.reload_wr),
    .line_pulse (line_pulse),
    .evt        (evt_w)
  );

  irqt_count_core #(.CNT_W(DATA_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt_w),
    .latch_wr  (cmd.latch_wr),
    .reload_wr (cmd.reload_wr),
    .wr_data   (wr_data),
    .src       (src),
    .latch_q   (latch_w),
    .cnt_q     (cnt_w),
    .reload_q  (reload_w),
    .zero_evt  (zero_w)
  );

  irqt_irq_out #(.DELAY(DELAY)) u_out (
    .clk      (clk),
    .rst      (rst),
    .zero_evt (zero_w),
    .en_set   (cmd.en_wr),
    .en_clr   (cmd.dis_wr),
    .en_q     (en_w),
    .dly_q    (dly_w),
    .irq_n    (irq_n)
  );

endmodule

// File: rtl/line_irq_timer_chk.sv
module line_irq_timer_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DW     = 3,
  parameter int DELAY  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              irq_n,
  input logic              evt,
  input logic              reload_q,
  input logic [DATA_W-1:0] latch_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic              en_q,
  input logic [DW-1:0]     dly_q
);

  logic ack_wr;
  assign ack_wr = wr_en && ((wr_addr & 16'hE001) == 16'hE000 ||
                            (wr_addr & 16'hE001) == 16'hE001);

  // R4 R5
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    ack_wr |=> irq_n);

  // R12
  irq_held_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !ack_wr) |=> !irq_n);

  // R8
  irq_after_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(dly_q == DW'(1)));

  // R11
  no_sched_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (dly_q != DW'(DELAY)));

  // R6
  forced_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && reload_q) |=> (cnt_q[0] || cnt_q == '0));

  // R6
  forced_zero_only_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && reload_q) |=> ((cnt_q == '0) == ($past(latch_q) == '0)));

endmodule

bind line_irq_timer line_irq_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DW(DW), .DELAY(DELAY)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .irq_n    (irq_n),
  .evt      (evt_w),
  .reload_q (reload_w),
  .latch_q  (latch_w),
  .cnt_q    (cnt_w),
  .en_q     (en_w),
  .dly_q    (dly_w)
);

// File: tb/test_line_irq_timer.sv
`timescale 1ns/1ps
module test_line_irq_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        line_pulse = 1'b0;
  logic        irq_n;

  int cyc = 0;
  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  line_irq_timer i_line_irq_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_pulse(line_pulse), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Write occupies exactly one edge; returns at the following negedge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Cycles from base until irq_n reads low, -1 if not within limit
  task automatic wait_irq(input int base, input int limit, output int t);
    t = -1;
    for (int i = 0; i < limit; i++) begin
      if (irq_n == 1'b0) begin t = cyc - base; break; end
      @(negedge clk);
    end
  endtask

  function automatic int cpu_latency(input int l);
    int n;
    n = (l == 0) ? 1 : ((l | 1) + 1);
    return 4 * n + 4;
  endfunction

  task automatic cpu_run(input int l, input bit mirror, output int w, output int t);
    wr(16'hE000, 8'h00);
    wr(mirror ? 16'hC0FE : 16'hC000, 8'(l));
    wr(16'h2000, 8'hAA);
    wr(16'h8001, 8'h00);
    wr(mirror ? 16'hDF01 : 16'hC001, 8'h01);
    w = cyc;
    wr(mirror ? 16'hFFFF : 16'hE001, 8'h00);
    wait_irq(w, 1200, t);
  endtask

  initial begin
    int w, t, f;
    idle(3);
    @(negedge clk) rst = 1'b0;
    // R12 reset state
    chk("R12 reset irq_n", irq_n, 1);
    // R10 R11 reset: scanline mode, disabled; pulses give no interrupt
    for (int p = 0; p < 6; p++) begin
      line_pulse = 1'b1; idle(3); line_pulse = 1'b0; idle(3);
    end
    chk("R11 no irq while disabled after reset", irq_n, 1);

    // R6 R7 R8 R9 R1 R2 R3 R5 sweep over latch values
    for (int l = 0; l < 256; l++) begin
      if (l > 63 && l < 250 && l != 128) continue;
      cpu_run(l, (l % 3) == 1, w, t);
      chk($sformatf("R6 R8 R9 latency latch=%0d", l), t, cpu_latency(l));
    end

    // R7 natural reload period with even latch, R5 ack
    cpu_run(4, 0, w, t);
    chk("R6 first latency latch=4", t, 28);
    f = cyc;
    wr(16'hE001, 8'h00);
    chk("R5 ack releases irq", irq_n, 1);
    wait_irq(f, 200, t);
    chk("R7 period after zero reload latch=4", t, 20);

    // R12 hold without ack, then R5 release
    cpu_run(100, 0, w, t);
    chk("R8 latency latch=100", t, cpu_latency(100));
    idle(30);
    chk("R12 irq held without ack", irq_n, 0);
    wr(16'hE001, 8'h00);
    chk("R5 release after hold", irq_n, 1);

    // R4 cancel a running delay
    wr(16'hE000, 8'h00);
    wr(16'hC000, 8'h00);
    wr(16'hC001, 8'h01);
    w = cyc;
    wr(16'hE001, 8'h00);
    while (cyc < w + 5) @(negedge clk);
    wr(16'hE000, 8'h00);
    idle(30);
    chk("R4 cancelled delay gives no irq", irq_n, 1);

    // R11 counting continues while disabled
    wr(16'hC000, 8'h02);
    wr(16'hC001, 8'h01);
    w = cyc;
    while (cyc < w + 40) @(negedge clk);
    chk("R11 disabled no irq", irq_n, 1);
    wr(16'hE001, 8'h00);
    wait_irq(w, 200, t);
    chk("R11 counter kept stepping while disabled", t, 56);

    // R10 scanline mode
    wr(16'hE000, 8'h00);
    wr(16'hC000, 8'h03);
    wr(16'hC001, 8'h00);
    wr(16'hE001, 8'h00);
    idle(60);
    chk("R10 clock cycles alone give no event", irq_n, 1);
    for (int p = 0; p < 3; p++) begin
      line_pulse = 1'b1; idle(3); line_pulse = 1'b0; idle(4);
    end
    idle(10);
    chk("R10 no irq after three pulses", irq_n, 1);
    w = cyc;
    line_pulse = 1'b1;
    @(negedge clk);
    wait_irq(w, 40, t);
    chk("R10 scanline latency", t, 7);
    line_pulse = 1'b0;
    wr(16'hE001, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    while (cyc < 150000 && !done) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL R12 watchdog actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule